// File: doc/BRIEF.md
# Processor Flush Write Buffer

This block sits between a processor core and its external bus interface. It queues outgoing traffic: uncached single-word and double-word stores, dirty cache-line writebacks, and at most one outstanding read request. It then hands that traffic to the bus in arrival order over a valid/ready handshake. The core keeps running while stores wait in the buffer. When a load or store needs the external bus and the buffer cannot take it, the core is stalled.

A request is presented in one cycle together with all of its data beats. A single-word or double-word write takes one entry. A data-cache line takes two entries and an instruction-cache line takes all four. Each entry carries a read/write flag, a transfer size code, a physical address and one 64-bit data word. A multi-entry block leaves the buffer as one burst. Its address is shown only on the first beat, and a last-beat flag marks the end of each request. On a miss to a dirty line, the core issues the read for the missing line first and the writeback after it. First-in, first-out draining therefore sends the read ahead of the dirty data.

Top module: `flush_buffer`

## Requirements
- R1: After reset, and whenever the buffer holds no entries, bus_valid_o is low; with no request present stall_o is low.
- R2: Each presented beat shows the stored fields: bus_rw_o (1 = read, 0 = write), the 4-bit size code given with the request on bus_size_o, and the 64-bit data word on bus_data_o. A read shows all-zero data.
- R3: Kind code 0 (word write) and kind code 1 (double-word write) take one entry each, with data from req_data_i[63:0]. Any mix of them is accepted until all four entries are in use.
- R4: Kind code 2 (data-cache line) takes two entries, with beat 0 from req_data_i[63:0] and beat 1 from req_data_i[127:64]. Two such lines fit at once.
- R5: Kind code 3 (instruction-cache line) takes four entries, with beat n from req_data_i[64n+63:64n]. It is accepted only into an empty buffer.
- R6: Kind code 4 (read) takes one entry. A second read is stalled for as long as an earlier read is still held, which is until the bus has taken the earlier read.
- R7: Entries leave in arrival order. A beat stays presented, unchanged, until bus_ready_i is high at a clock edge. bus_last_o is high on the final beat of each request and on every single-entry request.
- R8: The address appears on the first beat of a request only. The following beats of a block show bus_addr_o as zero.
- R9: stall_o is high exactly when req_valid_i is high and the request cannot be admitted. That happens when the entries it needs exceed the free entries counted before this cycle's drain, or when the R6 read rule applies. A stalled request stores nothing.
- R10: An admitted request and a drained beat in the same cycle both take effect, and the occupancy stays exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core presents a request this cycle |
| req_kind_i | input | 3 | Request kind: 0 word, 1 double-word, 2 data line, 3 instruction line, 4 read |
| req_size_i | input | 4 | Transfer size code, stored with every beat |
| req_addr_i | input | 32 | Physical address |
| req_data_i | input | 256 | Up to four 64-bit beats, beat 0 in the low bits |
| stall_o | output | 1 | Request cannot be admitted; core must hold |
| bus_valid_o | output | 1 | A beat is presented to the bus |
| bus_ready_i | input | 1 | Bus takes the presented beat |
| bus_rw_o | output | 1 | 1 read, 0 write |
| bus_size_o | output | 4 | Size code of the beat |
| bus_addr_o | output | 32 | Address, first beat only, else zero |
| bus_data_o | output | 64 | Data word of the beat |
| bus_last_o | output | 1 | Final beat of its request |

## Verification
The hardest conditions to reach are the ones where admission and draining interact. These are a request arriving in the very cycle the bus takes a beat from a full buffer, and a second read arriving in the cycle its predecessor is being taken. Both are stalled because admission looks only at the state before the drain. The directed part fills the buffer with the bus held off, then raises bus_ready_i together with a new request at exactly that moment. It also lines up a held read with a second read and a ready bus. A long random phase then mixes all five kinds with a randomly throttled bus, so that wrap-around of the storage and blocks split across the wrap point also occur.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned SIZE_W    = 4;
  localparam int unsigned KIND_W    = 3;
  localparam int unsigned DBLK_BEATS = 2;
  localparam int unsigned IBLK_BEATS = 4;

  typedef enum logic [KIND_W-1:0] {
    K_WORD  = 3'd0,
    K_DWORD = 3'd1,
    K_DBLK  = 3'd2,
    K_IBLK  = 3'd3,
    K_READ  = 3'd4
  } req_kind_e;

  typedef struct packed {
    logic              rw;
    logic [SIZE_W-1:0] size;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              last;
  } entry_t;

  function automatic int unsigned beats_of(req_kind_e k);
    case (k)
      K_DBLK:  return DBLK_BEATS;
      K_IBLK:  return IBLK_BEATS;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/fbuf_admit.sv
module fbuf_admit
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             valid_i,
  input  req_kind_e        kind_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             rd_held_i,
  output logic [CNT_W-1:0] need_o,
  output logic             accept_o,
  output logic             stall_o
);
  logic [CNT_W-1:0] free;
  logic             fits;
  logic             rd_block;

  assign need_o   = CNT_W'(beats_of(kind_i));
  assign free     = CNT_W'(DEPTH) - count_i;
  assign fits     = need_o <= free;
  assign rd_block = (kind_i == K_READ) && rd_held_i;
  // admission uses pre-drain occupancy only
  assign accept_o = valid_i && fits && !rd_block;
  assign stall_o  = valid_i && !accept_o;
endmodule

// File: rtl/fbuf_store.sv
module fbuf_store
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned BEATS = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_read_i,
  input  logic [CNT_W-1:0] wr_beats_i,
  input  entry_t           wr_ent_i [BEATS],
  input  logic             rd_en_i,
  output entry_t           head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             rd_held_o
);
  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign head_o = mem[rd_ptr];

  for (genvar i = 0; i < BEATS; i++) begin : g_wr
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (CNT_W'(i) < wr_beats_i))
        mem[PTR_W'(wr_ptr + PTR_W'(i))] <= wr_ent_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count_o   <= '0;
      rd_held_o <= 1'b0;
    end else begin
      if (wr_en_i) wr_ptr <= PTR_W'(wr_ptr + PTR_W'(wr_beats_i));
      if (rd_en_i) rd_ptr <= PTR_W'(rd_ptr + PTR_W'(1));
      count_o <= count_o + (wr_en_i ? wr_beats_i : '0) - CNT_W'(rd_en_i);
      if (wr_en_i && wr_read_i)      rd_held_o <= 1'b1;
      else if (rd_en_i && head_o.rw) rd_held_o <= 1'b0;
    end
  end
endmodule

// File: rtl/flush_buffer.sv
module flush_buffer
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned BEATS = IBLK_BEATS
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [KIND_W-1:0]        req_kind_i,
  input  logic [SIZE_W-1:0]        req_size_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [BEATS*DATA_W-1:0]  req_data_i,
  output logic                     stall_o,
  output logic                     bus_valid_o,
  input  logic                     bus_ready_i,
  output logic                     bus_rw_o,
  output logic [SIZE_W-1:0]        bus_size_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_data_o,
  output logic                     bus_last_o
);
  req_kind_e        kind;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] count;
  logic             rd_held;
  logic             accept;
  logic             drain;
  entry_t           head;
  entry_t           wr_ent [BEATS];

  assign kind = req_kind_e'(req_kind_i);

  fbuf_admit #(.DEPTH(DEPTH)) u_admit (
    .valid_i   (req_valid_i),
    .kind_i    (kind),
    .count_i   (count),
    .rd_held_i (rd_held),
    .need_o    (need),
    .accept_o  (accept),
    .stall_o   (stall_o)
  );

  for (genvar i = 0; i < BEATS; i++) begin : g_beat
    always_comb begin
      wr_ent[i].rw   = (kind == K_READ);
      wr_ent[i].size = req_size_i;
      wr_ent[i].addr = (i == 0) ? req_addr_i : '0;
      wr_ent[i].data = (kind == K_READ) ? '0 : req_data_i[i*DATA_W +: DATA_W];
      wr_ent[i].last = (CNT_W'(i + 1) == need);
    end
  end

  assign drain = bus_valid_o && bus_ready_i;

  fbuf_store #(.DEPTH(DEPTH), .BEATS(BEATS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (accept),
    .wr_read_i  (kind == K_READ),
    .wr_beats_i (need),
    .wr_ent_i   (wr_ent),
    .rd_en_i    (drain),
    .head_o     (head),
    .count_o    (count),
    .rd_held_o  (rd_held)
  );

  assign bus_valid_o = (count != '0);
  assign bus_rw_o    = bus_valid_o && head.rw;
  assign bus_size_o  = bus_valid_o ? head.size : '0;
  assign bus_addr_o  = bus_valid_o ? head.addr : '0;
  assign bus_data_o  = bus_valid_o ? head.data : '0;
  assign bus_last_o  = bus_valid_o && head.last;
endmodule

// File: rtl/fbuf_chk.sv
module fbuf_chk
  import fbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [KIND_W-1:0]  req_kind_i,
  input logic               stall_o,
  input logic               bus_valid_o,
  input logic               bus_ready_i,
  input logic [ADDR_W-1:0]  bus_addr_o,
  input logic [DATA_W-1:0]  bus_data_o,
  input logic               bus_last_o,
  input logic [CNT_W-1:0]   count,
  input logic               rd_held
);
  logic             in_burst;
  logic [CNT_W-1:0] req_beats;

  always_comb begin
    case (req_kind_i)
      3'd2:    req_beats = CNT_W'(DBLK_BEATS);
      3'd3:    req_beats = CNT_W'(IBLK_BEATS);
      default: req_beats = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_burst <= 1'b0;
    else if (bus_valid_o && bus_ready_i) in_burst <= !bus_last_o;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R1
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> !bus_valid_o);

  // R6
  second_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 3'd4 && rd_held) |-> stall_o);

  // R7
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_o && !bus_ready_i) |=> (bus_valid_o && $stable(bus_addr_o)
      && $stable(bus_data_o) && $stable(bus_last_o)));

  // R8
  addr_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_burst && bus_valid_o) |-> (bus_addr_o == '0));

  // R10
  occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (count == $past(count)
         + ($past(req_valid_i && !stall_o) ? $past(req_beats) : '0)
         - CNT_W'($past(bus_valid_o && bus_ready_i))));
endmodule

bind flush_buffer fbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_kind_i  (req_kind_i),
  .stall_o     (stall_o),
  .bus_valid_o (bus_valid_o),
  .bus_ready_i (bus_ready_i),
  .bus_addr_o  (bus_addr_o),
  .bus_data_o  (bus_data_o),
  .bus_last_o  (bus_last_o),
  .count       (count),
  .rd_held     (rd_held)
);

// File: tb/flush_buffer_bench.sv
module flush_buffer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [2:0]   req_kind = '0;
  logic [3:0]   req_size = '0;
  logic [31:0]  req_addr = '0;
  logic [255:0] req_data = '0;
  logic         bus_ready = 1'b0;
  logic         stall, bus_valid, bus_rw, bus_last;
  logic [3:0]   bus_size;
  logic [31:0]  bus_addr;
  logic [63:0]  bus_data;

  always #2 clk = ~clk;

  flush_buffer u_flush_buffer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_size_i(req_size), .req_addr_i(req_addr), .req_data_i(req_data),
    .stall_o(stall), .bus_valid_o(bus_valid), .bus_ready_i(bus_ready),
    .bus_rw_o(bus_rw), .bus_size_o(bus_size), .bus_addr_o(bus_addr),
    .bus_data_o(bus_data), .bus_last_o(bus_last)
  );

  typedef struct {
    bit        rw;
    bit [3:0]  size;
    bit [31:0] addr;
    bit [63:0] data;
    bit        last;
  } ent_t;

  ent_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int beats(logic [2:0] k);
    if (k == 3'd2) return 2;
    if (k == 3'd3) return 4;
    return 1;
  endfunction

  function automatic bit has_read();
    foreach (q[i]) if (q[i].rw) return 1'b1;
    return 1'b0;
  endfunction

  // one cycle: drive at negedge, compare, advance model, cross posedge
  task automatic cycle(bit v, logic [2:0] k, logic [3:0] sz, logic [31:0] a,
                       logic [255:0] d, bit rdy, string tag);
    bit exp_stall, fire;
    int n;
    req_valid = v; req_kind = k; req_size = sz; req_addr = a; req_data = d;
    bus_ready = rdy;
    #1;
    n = beats(k);
    exp_stall = v && ((n > 4 - q.size()) || (k == 3'd4 && has_read()));
    chk(tag, "stall", 64'(stall), 64'(exp_stall));
    chk("R7", "valid", 64'(bus_valid), 64'(q.size() > 0));
    if (q.size() > 0) begin
      chk("R2", "rw", 64'(bus_rw), 64'(q[0].rw));
      chk("R2", "size", 64'(bus_size), 64'(q[0].size));
      chk("R2", "data", bus_data, q[0].data);
      chk("R8", "addr", 64'(bus_addr), 64'(q[0].addr));
      chk("R7", "last", 64'(bus_last), 64'(q[0].last));
    end
    fire = (q.size() > 0) && rdy;
    if (v && !exp_stall) begin
      for (int i = 0; i < n; i++) begin
        ent_t e;
        e.rw   = (k == 3'd4);
        e.size = sz;
        e.addr = (i == 0) ? a : 32'h0;
        e.data = (k == 3'd4) ? 64'h0 : d[i*64 +: 64];
        e.last = (i == n - 1);
        q.push_back(e);
      end
    end
    if (fire) void'(q.pop_front());
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [255:0] rdat();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic idle(int n, bit rdy);
    for (int i = 0; i < n; i++) cycle(0, 3'd0, 4'd0, 32'd0, '0, rdy, "R7");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "reset valid", 64'(bus_valid), 64'd0);
    chk("R1", "reset stall", 64'(stall), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle(1, 0); // R1

    // R3: four single entries fill the buffer, fifth stalls (R9)
    cycle(1, 3'd0, 4'h2, 32'h1000, rdat(), 0, "R3");
    cycle(1, 3'd1, 4'h3, 32'h1008, rdat(), 0, "R3");
    cycle(1, 3'd0, 4'h2, 32'h1010, rdat(), 0, "R3");
    cycle(1, 3'd1, 4'h3, 32'h1018, rdat(), 0, "R3");
    cycle(1, 3'd0, 4'h2, 32'h1020, rdat(), 0, "R9");
    idle(5, 1); // R7 order

    // R4: two data lines fit, third and a word stall
    cycle(1, 3'd2, 4'h7, 32'h2000, rdat(), 0, "R4");
    cycle(1, 3'd2, 4'h7, 32'h2040, rdat(), 0, "R4");
    cycle(1, 3'd2, 4'h7, 32'h2080, rdat(), 0, "R4");
    cycle(1, 3'd0, 4'h2, 32'h20c0, rdat(), 0, "R9");
    idle(5, 1); // R8 bursts

    // R5: instruction line needs an empty buffer
    cycle(1, 3'd0, 4'h2, 32'h3000, rdat(), 0, "R3");
    cycle(1, 3'd3, 4'hf, 32'h3100, rdat(), 0, "R5");
    cycle(1, 3'd3, 4'hf, 32'h3100, rdat(), 1, "R5");
    cycle(1, 3'd3, 4'hf, 32'h3100, rdat(), 0, "R5");
    cycle(1, 3'd0, 4'h2, 32'h3200, rdat(), 0, "R5");
    idle(5, 1);

    // R6: read then writeback; second read stalls even while first drains
    cycle(1, 3'd4, 4'h7, 32'h4000, rdat(), 0, "R6");
    cycle(1, 3'd2, 4'h7, 32'h4800, rdat(), 0, "R4");
    cycle(1, 3'd4, 4'h7, 32'h4040, rdat(), 0, "R6");
    cycle(1, 3'd4, 4'h7, 32'h4040, rdat(), 1, "R6");
    cycle(1, 3'd4, 4'h7, 32'h4040, rdat(), 0, "R6");
    idle(5, 1);

    // R10: enqueue and drain together
    cycle(1, 3'd0, 4'h2, 32'h5000, rdat(), 0, "R10");
    cycle(1, 3'd0, 4'h2, 32'h5004, rdat(), 0, "R10");
    cycle(1, 3'd0, 4'h2, 32'h5008, rdat(), 0, "R10");
    cycle(1, 3'd1, 4'h3, 32'h500c, rdat(), 1, "R10");
    cycle(1, 3'd1, 4'h3, 32'h5010, rdat(), 1, "R10");
    // full buffer: drain this cycle does not free room for admission (R9)
    cycle(1, 3'd0, 4'h2, 32'h5018, rdat(), 0, "R9");
    cycle(1, 3'd0, 4'h2, 32'h5018, rdat(), 1, "R9");
    cycle(1, 3'd0, 4'h2, 32'h5020, rdat(), 1, "R10");
    idle(6, 1);

    // mixed traffic with throttled bus
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] k = 3'($urandom_range(0, 4));
      cycle(($urandom_range(0, 3) != 0), k, 4'($urandom), $urandom, rdat(),
            ($urandom_range(0, 2) != 0), "R9");
    end
    idle(8, 1);
    chk("R1", "empty at end", 64'(bus_valid), 64'd0);
    finish_run();
  end
endmodule